// File: doc/BRIEF.md
# Byte-serial instruction fetch unit

This block fetches 32-bit instruction words for a small multicycle processor whose memory bus is only one byte wide. A fetch is four back-to-back byte reads. Each byte lands in its own 8-bit slot of an instruction register, selected by one bit of a slot write-enable vector. The block also owns the program counter. The counter steps by one for every byte fetched, and it can be reloaded between instructions from a jump target or, when the zero flag is set, from a branch-equal target.

The memory attached to this block registers its read data, and it is clocked on the falling edge of the block clock. The block drives the address, the read request and the slot enable just after a rising edge. The memory registers the byte half a cycle later, and the block captures it on the following rising edge. Every byte therefore costs one clock. Once the fourth byte is in, the block raises an instruction-valid pulse for one cycle. It then waits for the execute side to request the next fetch, and that request may carry a program-counter reload. Decoding, the register file and the ALU belong to other blocks.

Top module: `byte_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `pc` and `instr` to zero and returns to fetching slot 0. The outputs then show `mem_rd`=1, `slot_we`=4'b0001, `mem_addr`=0 and `instr_valid`=0.
- R2: In every fetch cycle, `mem_addr` equals `pc` and `mem_rd` is 1. Exactly one `slot_we` bit is set: bit i during the i-th byte of the instruction, counting from 0. Outside a fetch, `mem_rd` is 0 and `slot_we` is 0.
- R3: The byte returned for slot i is written into `instr[8*i+7:8*i]` on the rising edge that ends that fetch cycle. The first byte therefore fills bits 7:0 and the fourth fills bits 31:24.
- R4: `pc` increments by one, modulo 256, at the end of each byte fetch. After a complete instruction, `pc` equals the start address plus 4, wrapping from 255 to 0.
- R5: In the cycle after the fourth byte is captured, `instr_valid` is 1 for exactly one cycle and `instr` holds the complete word. The block then enters a wait state with `instr_valid`=0.
- R6: In the wait state, the block issues no reads and `pc` is stable until `next_fetch` is seen high at a rising edge. The next cycle then fetches slot 0 from the current `pc`, unless a reload applies.
- R7: If `jump_req` is high together with `next_fetch` in the wait state, `pc` is loaded with `jump_tgt`.
- R8: If `beq_req` and `zero` are both high together with `next_fetch` in the wait state, and `jump_req` is low, `pc` is loaded with `beq_tgt`. If `zero` is low, the branch request leaves `pc` unchanged.
- R9: When `jump_req` and a taken branch-equal request arrive together, the jump target wins.
- R10: `next_fetch`, `jump_req` and `beq_req` have no effect during a fetch or during the valid cycle. The byte sequence and `pc` proceed as if the requests were absent.
- R11: A slot of `instr` changes only on the edge where its `slot_we` bit is set. While waiting and in the first cycle of a new fetch, the previous word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock. The attached memory runs on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| next_fetch | input | 1 | Starts the next instruction fetch while waiting |
| jump_req | input | 1 | Unconditional program-counter reload request |
| jump_tgt | input | 8 | Jump target address |
| beq_req | input | 1 | Branch-equal reload request, qualified by `zero` |
| zero | input | 1 | Zero flag from the ALU |
| beq_tgt | input | 8 | Branch target address |
| mem_rdata | input | 8 | Registered read data from memory |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory byte address |
| slot_we | output | 4 | Per-slot instruction register write enables |
| instr | output | 32 | Assembled instruction word |
| instr_valid | output | 1 | One-cycle pulse when `instr` is complete |
| pc | output | 8 | Program counter |

## Verification
Address, read request and slot enable change with the rising edge that enters a fetch cycle, so the bench checks them just after that edge. Each byte reaches `instr` one rising edge later, through the memory model's falling-edge register. The complete word, `pc` at start plus 4, and the `instr_valid` pulse are all due exactly four edges after the first byte request. The bench therefore checks them after the fourth step, and checks the end of the pulse one step later. A reload requested with `next_fetch` appears on `pc` and `mem_addr` on the very next edge. Every check samples 2 ns after the rising edge that makes its result due. The expected words are built from the bench's own memory image.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int ADDR_W_DEF = 8;
    localparam int BYTE_W_DEF = 8;
    localparam int SLOTS_DEF  = 4;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_ISSUE = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    // Decoded phase flags handed from the sequencer to the datapath
    typedef struct packed {
        logic fetching;
        logic issue;
        logic hold;
    } seq_ctl_t;

    function automatic logic branch_taken(input logic beq, input logic zf);
        return beq & zf;
    endfunction

endpackage

// File: rtl/ifu_seq.sv
module ifu_seq
    import ifu_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             next_fetch,
    output seq_ctl_t         ctl,
    output logic [SLOTS-1:0] slot_we
);
    localparam int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SLOT_IW-1:0] LAST_IDX = SLOT_IW'(SLOTS - 1);

    phase_e             phase;
    logic [SLOT_IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            idx   <= '0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    if (idx == LAST_IDX) begin
                        phase <= PH_ISSUE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + SLOT_IW'(1);
                    end
                end
                PH_ISSUE: phase <= PH_HOLD;
                PH_HOLD:  if (next_fetch) phase <= PH_FETCH;
                default:  phase <= PH_FETCH;
            endcase
        end
    end

    always_comb begin
        ctl.fetching = (phase == PH_FETCH);
        ctl.issue    = (phase == PH_ISSUE);
        ctl.hold     = (phase == PH_HOLD);
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot_en
        assign slot_we[g] = ctl.fetching && (idx == SLOT_IW'(g));
    end

    // R2: at most one slot written per cycle
    a_r2_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_we));

    // R5: the valid cycle lasts one cycle and leads into the wait state
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ctl.issue |=> (!ctl.issue && ctl.hold));

    // R6: waiting persists without a fetch request
    a_r6_keep_waiting: assert property (@(posedge clk) disable iff (rst)
        (ctl.hold && !next_fetch) |=> ctl.hold);

    // R6: a fetch request in the wait state starts slot 0
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (ctl.hold && next_fetch) |=> slot_we[0]);

endmodule

// File: rtl/ifu_pc.sv
module ifu_pc
    import ifu_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetching,
    input  logic              hold,
    input  logic              next_fetch,
    input  logic              jump_req,
    input  logic [ADDR_W-1:0] jump_tgt,
    input  logic              beq_req,
    input  logic              zero,
    input  logic [ADDR_W-1:0] beq_tgt,
    output logic [ADDR_W-1:0] pc
);
    logic [ADDR_W-1:0] pc_nxt;
    logic              reload_win;

    assign reload_win = hold && next_fetch;

    always_comb begin
        pc_nxt = pc;
        if (fetching) begin
            pc_nxt = pc + ADDR_W'(1);
        end else if (reload_win) begin
            if (jump_req)
                pc_nxt = jump_tgt;
            else if (branch_taken(beq_req, zero))
                pc_nxt = beq_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_nxt;
    end

    // R4: one step per fetched byte
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        fetching |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

    // R7, R9: jump reload, which wins over a branch
    a_r7_jump_load: assert property (@(posedge clk) disable iff (rst)
        (hold && next_fetch && jump_req) |=> (pc == $past(jump_tgt)));

    // R8: taken branch-equal reload
    a_r8_beq_load: assert property (@(posedge clk) disable iff (rst)
        (hold && next_fetch && !jump_req && beq_req && zero) |=> (pc == $past(beq_tgt)));

    // R10: no write outside a fetch or a reload window
    a_r10_pc_quiet: assert property (@(posedge clk) disable iff (rst)
        (!fetching && !(hold && next_fetch)) |=> $stable(pc));

endmodule

// File: rtl/ifu_ir.sv
module ifu_ir
    import ifu_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int SLOTS  = SLOTS_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SLOTS-1:0]        slot_we,
    input  logic [BYTE_W-1:0]       rdata,
    output logic [BYTE_W*SLOTS-1:0] instr
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                instr[g*BYTE_W +: BYTE_W] <= '0;
            else if (slot_we[g])
                instr[g*BYTE_W +: BYTE_W] <= rdata;
        end

        // R3: enabled slot takes the returned byte
        a_r3_capture: assert property (@(posedge clk) disable iff (rst)
            slot_we[g] |=> (instr[g*BYTE_W +: BYTE_W] == $past(rdata)));

        // R11: disabled slot keeps its byte
        a_r11_keep: assert property (@(posedge clk) disable iff (rst)
            !slot_we[g] |=> $stable(instr[g*BYTE_W +: BYTE_W]));
    end

endmodule

// File: rtl/byte_fetch_unit.sv
module byte_fetch_unit
    import ifu_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int SLOTS  = SLOTS_DEF,
    localparam int INSTR_W = BYTE_W * SLOTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               next_fetch,
    input  logic               jump_req,
    input  logic [ADDR_W-1:0]  jump_tgt,
    input  logic               beq_req,
    input  logic               zero,
    input  logic [ADDR_W-1:0]  beq_tgt,
    input  logic [BYTE_W-1:0]  mem_rdata,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [SLOTS-1:0]   slot_we,
    output logic [INSTR_W-1:0] instr,
    output logic               instr_valid,
    output logic [ADDR_W-1:0]  pc
);
    seq_ctl_t ctl;

    ifu_seq #(.SLOTS(SLOTS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .next_fetch (next_fetch),
        .ctl        (ctl),
        .slot_we    (slot_we)
    );

    ifu_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .fetching   (ctl.fetching),
        .hold       (ctl.hold),
        .next_fetch (next_fetch),
        .jump_req   (jump_req),
        .jump_tgt   (jump_tgt),
        .beq_req    (beq_req),
        .zero       (zero),
        .beq_tgt    (beq_tgt),
        .pc         (pc)
    );

    ifu_ir #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_ir (
        .clk     (clk),
        .rst     (rst),
        .slot_we (slot_we),
        .rdata   (mem_rdata),
        .instr   (instr)
    );

    // The memory samples the address on the falling edge, so the address
    // comes straight from the counter with no extra stage.
    assign mem_addr    = pc;
    assign mem_rd      = ctl.fetching;
    assign instr_valid = ctl.issue;

    // R2: read request and slot enable always agree
    a_r2_rd_slot_agree: assert property (@(posedge clk) disable iff (rst)
        mem_rd == (slot_we != '0));

    // R5: valid follows the last slot
    a_r5_valid_after_last: assert property (@(posedge clk) disable iff (rst)
        slot_we[SLOTS-1] |=> instr_valid);

endmodule

// File: tb/sim_byte_fetch_unit.sv
module sim_byte_fetch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        next_fetch = 1'b0;
    logic        jump_req = 1'b0;
    logic [7:0]  jump_tgt = '0;
    logic        beq_req = 1'b0;
    logic        zero = 1'b0;
    logic [7:0]  beq_tgt = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic [3:0]  slot_we;
    logic [31:0] instr;
    logic        instr_valid;
    logic [7:0]  pc;

    logic [7:0]  mem [256];
    int          vectors = 0;
    int          errors  = 0;
    bit          done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Byte memory with registered read, clocked on the falling edge
    always @(negedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    byte_fetch_unit u0 (
        .clk(clk), .rst(rst), .next_fetch(next_fetch), .jump_req(jump_req),
        .jump_tgt(jump_tgt), .beq_req(beq_req), .zero(zero), .beq_tgt(beq_tgt),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .slot_we(slot_we), .instr(instr), .instr_valid(instr_valid), .pc(pc)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [7:0] a);
        return {mem[8'(a + 8'd3)], mem[8'(a + 8'd2)], mem[8'(a + 8'd1)], mem[a]};
    endfunction

    task automatic clear_reqs();
        next_fetch = 1'b0; jump_req = 1'b0; beq_req = 1'b0; zero = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk("R1 pc", 32'(pc), 32'h0);
        chk("R1 instr", instr, 32'h0);
        chk("R1 mem_rd", 32'(mem_rd), 32'h1);
        chk("R1 slot_we", 32'(slot_we), 32'h1);
        chk("R1 mem_addr", 32'(mem_addr), 32'h0);
        chk("R1 instr_valid", 32'(instr_valid), 32'h0);
        rst = 1'b0;
    endtask

    // Called just after the edge that enters slot 0 of a fetch
    task automatic t_fetch(input logic [7:0] start, input bit disturb);
        for (int i = 0; i < 4; i++) begin
            chk("R2 mem_addr", 32'(mem_addr), 32'(8'(start + 8'(i))));
            chk("R2 slot_we", 32'(slot_we), 32'(4'b0001 << i));
            chk("R2 mem_rd", 32'(mem_rd), 32'h1);
            chk("R4 pc during fetch", 32'(pc), 32'(8'(start + 8'(i))));
            if (disturb && i == 1) begin   // R10 stimulus
                next_fetch = 1'b1; jump_req = 1'b1; jump_tgt = 8'h77;
                beq_req = 1'b1; zero = 1'b1; beq_tgt = 8'h66;
            end
            step();
            clear_reqs();
        end
        chk("R3 assembled word", instr, word_at(start));
        chk("R5 valid pulse", 32'(instr_valid), 32'h1);
        chk("R4 pc after word", 32'(pc), 32'(8'(start + 8'd4)));
        chk("R5 no read in valid cycle", 32'(mem_rd), 32'h0);
        if (disturb) chk("R10 pc unaffected", 32'(pc), 32'(8'(start + 8'd4)));
        step();
        chk("R5 pulse ended", 32'(instr_valid), 32'h0);
        chk("R2 no read while waiting", 32'(mem_rd), 32'h0);
        chk("R2 no slot while waiting", 32'(slot_we), 32'h0);
        chk("R11 word held", instr, word_at(start));
    endtask

    // Idle in the wait state, then request the next fetch with optional reloads
    task automatic t_launch(input string req, input bit jmp, input bit beq, input bit zf,
                            input logic [7:0] jt, input logic [7:0] bt,
                            input logic [7:0] exp_pc);
        logic [7:0]  pc_before;
        logic [31:0] w_before;
        pc_before = pc;
        w_before  = instr;
        step(); step();
        chk("R6 pc stable while waiting", 32'(pc), 32'(pc_before));
        chk("R6 no read while waiting", 32'(mem_rd), 32'h0);
        next_fetch = 1'b1; jump_req = jmp; beq_req = beq; zero = zf;
        jump_tgt = jt; beq_tgt = bt;
        step();
        clear_reqs();
        chk(req, 32'(pc), 32'(exp_pc));
        chk("R6 fetch restarted at slot 0", 32'(slot_we), 32'h1);
        chk("R11 word held into new fetch", instr, w_before);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
        t_reset();
        t_fetch(8'h00, 1'b0);
        t_launch("R6 sequential continue", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h04);
        t_fetch(8'h04, 1'b0);
        t_launch("R7 jump load", 1'b1, 1'b0, 1'b0, 8'h40, 8'h00, 8'h40);
        t_fetch(8'h40, 1'b0);
        t_launch("R8 branch taken", 1'b0, 1'b1, 1'b1, 8'h00, 8'h90, 8'h90);
        t_fetch(8'h90, 1'b0);
        t_launch("R8 branch not taken", 1'b0, 1'b1, 1'b0, 8'h00, 8'h20, 8'h94);
        t_fetch(8'h94, 1'b0);
        t_launch("R9 jump over branch", 1'b1, 1'b1, 1'b1, 8'h10, 8'h30, 8'h10);
        t_fetch(8'h10, 1'b0);
        t_launch("R6 continue", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h14);
        t_fetch(8'h14, 1'b1);
        t_launch("R7 jump near top", 1'b1, 1'b0, 1'b0, 8'hFE, 8'h00, 8'hFE);
        t_fetch(8'hFE, 1'b0);   // R4 wrap: ends at 8'h02
        t_launch("R4 wrapped pc", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h02);
        t_fetch(8'h02, 1'b0);
        t_reset();
        t_fetch(8'h00, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule